// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block is an 8-bit binary down-counter paced by one of four tick enables. The tick enables come from a divider outside the block, which is fed by a 32.768 kHz base. Software loads a start value and picks a tick rate. It then turns the counter on.

Each time the count runs out, the counter reloads the stored start value and keeps going. At the same moment it raises a sticky timer flag. The interrupt has two modes:

- **Level mode:** the interrupt follows the flag.
- **Pulse mode:** the interrupt is a short pulse, one per period.

The live count is always visible on an output. Setting the start value to zero parks the timer.

All state is updated on the rising edge of a single clock. The tick inputs are one-cycle enables, and each control field has its own write strobe.

Top module: `tmr_top`

## Requirements
- R1: After reset the count is 0, the flag is 0, `irq_n` is 1, the counter is off, the interrupt enable is 0, level mode is selected and the source select is 3. Source 3 means only `tick_min` advances the counter.
- R2: The source select picks which tick advances the counter: 0 = `tick_4k`, 1 = `tick_64`, 2 = `tick_1`, 3 = `tick_min`. Ticks that are not selected have no effect on the count.
- R3: While the run bit is 1, each selected tick lowers the count by one. While the run bit is 0, the count holds.
- R4: A count write loads both the live count and the stored reload value. The new value appears on `count` after that edge, and a write wins over a tick in the same cycle.
- R5: A selected tick that arrives while the count is 1 reloads the stored value. On that same edge the flag is set.
- R6: When the stored value is 0, ticks leave the count at 0 and never set the flag.
- R7: The flag stays set until `flag_clr` is pulsed. If a countdown ends in the same cycle as a clear, the flag stays set.
- R8: In level mode with the interrupt enabled, `irq_n` is the inverse of the flag.
- R9: In pulse mode with the interrupt enabled, `irq_n` goes low on the edge where the countdown ends. It returns high on the next selected tick, or on the next `tick_64` when the source is 3, while the flag stays set.
- R10: With the interrupt enable at 0, `irq_n` stays 1 whatever the flag and pulse are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_4k | input | 1 | 4096 Hz tick enable |
| tick_64 | input | 1 | 64 Hz tick enable |
| tick_1 | input | 1 | 1 Hz tick enable |
| tick_min | input | 1 | One-per-minute tick enable |
| run_wr | input | 1 | Write strobe for the run bit |
| run_val | input | 1 | Run bit value |
| src_wr | input | 1 | Write strobe for the source select |
| src_val | input | 2 | Source select value |
| mode_wr | input | 1 | Write strobe for the interrupt enable and mode |
| ie_val | input | 1 | Interrupt enable value |
| pulse_val | input | 1 | 1 = pulse mode, 0 = level mode |
| cnt_wr | input | 1 | Write strobe for the count |
| cnt_val | input | 8 | Start value to load |
| flag_clr | input | 1 | Clears the timer flag |
| count | output | 8 | Live count |
| flag | output | 1 | Sticky timer flag |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The hardest situation to reach is a pulse that ends while the flag stays set under the slowest source. There, the pulse is not ended by the tick that drives the counter but by `tick_64`.

The bench loads a count of 1 with source 3 and ends the countdown with one `tick_min`. It then sends a 1 Hz tick, which must not end the pulse, followed by a 64 Hz tick, which must.

The other awkward cases are a clear that coincides with the end of a countdown, and a count write that coincides with a tick. Both are reached by driving the two inputs in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_CNT_W = 8;
  localparam int TMR_NSRC  = 4;
  localparam int TMR_SRC_W = $clog2(TMR_NSRC);

  typedef enum logic [TMR_SRC_W-1:0] {
    SRC_4K  = 2'd0,
    SRC_64  = 2'd1,
    SRC_1   = 2'd2,
    SRC_MIN = 2'd3
  } tmr_src_e;
endpackage

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_wr,
  input  logic                 run_val,
  input  logic                 src_wr,
  input  logic [TMR_SRC_W-1:0] src_val,
  input  logic                 mode_wr,
  input  logic                 ie_val,
  input  logic                 pulse_val,
  output logic                 run,
  output tmr_src_e             src,
  output logic                 ie,
  output logic                 pmode
);
  logic     run_d, ie_d, pmode_d;
  tmr_src_e src_d;

  always_comb begin
    run_d   = run;
    src_d   = src;
    ie_d    = ie;
    pmode_d = pmode;
    if (run_wr) run_d = run_val;
    if (src_wr) src_d = tmr_src_e'(src_val);
    if (mode_wr) begin
      ie_d    = ie_val;
      pmode_d = pulse_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      src   <= SRC_MIN;
      ie    <= 1'b0;
      pmode <= 1'b0;
    end else begin
      run   <= run_d;
      src   <= src_d;
      ie    <= ie_d;
      pmode <= pmode_d;
    end
  end

  a_r1_src_default: assert property (@(posedge clk)
    $rose(rst_n) |-> (src == SRC_MIN));
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
(
  input  logic [TMR_NSRC-1:0] ticks,
  input  tmr_src_e            src,
  output logic                step,
  output logic                pend
);
  always_comb begin
    step = ticks[src];
    // at the slowest rate the pulse is ended by the 64 Hz tick
    if (src == SRC_MIN) pend = ticks[SRC_64];
    else                pend = ticks[src];
  end
endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         run,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic         expire
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_d, rld_q, rld_d;

  always_comb begin
    cnt_d  = count;
    rld_d  = rld_q;
    expire = 1'b0;
    if (wr) begin
      cnt_d = wdata;
      rld_d = wdata;
    end else if (run && step && (rld_q != ZERO)) begin
      if (count == ONE || count == ZERO) begin
        cnt_d  = rld_q;
        expire = 1'b1;
      end else begin
        cnt_d = count - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= ZERO;
      rld_q <= ZERO;
    end else begin
      count <= cnt_d;
      rld_q <= rld_d;
    end
  end

  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr) |=> $stable(count));
  a_r4_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (count == $past(wdata)));
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !wr && count == ONE) |=> (count == $past(rld_q)));
  a_r6_zero_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_q == ZERO && count == ZERO && !wr) |=> (count == ZERO));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic pend,
  input  logic clr,
  input  logic ie,
  input  logic pmode,
  output logic flag,
  output logic irq_n
);
  logic flag_d, pul_q, pul_d;

  always_comb begin
    flag_d = flag;
    if (clr)    flag_d = 1'b0;
    if (expire) flag_d = 1'b1;
    pul_d = pul_q;
    if (pend)   pul_d = 1'b0;
    if (expire) pul_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      pul_q <= 1'b0;
    end else begin
      flag  <= flag_d;
      pul_q <= pul_d;
    end
  end

  assign irq_n = !(ie && (pmode ? pul_q : flag));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  a_r5_flag_and_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (flag && pul_q));
  a_r9_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pul_q && !pend) |=> pul_q);
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> irq_n);
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_4k,
  input  logic                 tick_64,
  input  logic                 tick_1,
  input  logic                 tick_min,
  input  logic                 run_wr,
  input  logic                 run_val,
  input  logic                 src_wr,
  input  logic [TMR_SRC_W-1:0] src_val,
  input  logic                 mode_wr,
  input  logic                 ie_val,
  input  logic                 pulse_val,
  input  logic                 cnt_wr,
  input  logic [TMR_CNT_W-1:0] cnt_val,
  input  logic                 flag_clr,
  output logic [TMR_CNT_W-1:0] count,
  output logic                 flag,
  output logic                 irq_n
);
  logic                run, ie, pmode, step, pend, expire;
  tmr_src_e            src;
  logic [TMR_NSRC-1:0] ticks;

  assign ticks = {tick_min, tick_1, tick_64, tick_4k};

  tmr_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .run_wr(run_wr), .run_val(run_val),
    .src_wr(src_wr), .src_val(src_val),
    .mode_wr(mode_wr), .ie_val(ie_val), .pulse_val(pulse_val),
    .run(run), .src(src), .ie(ie), .pmode(pmode)
  );

  tmr_tick_sel u_sel (
    .ticks(ticks), .src(src), .step(step), .pend(pend)
  );

  tmr_down #(.W(TMR_CNT_W)) u_down (
    .clk(clk), .rst_n(rst_n), .step(step), .run(run),
    .wr(cnt_wr), .wdata(cnt_val), .count(count), .expire(expire)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .pend(pend),
    .clr(flag_clr), .ie(ie), .pmode(pmode), .flag(flag), .irq_n(irq_n)
  );
endmodule

// File: tb/test_tmr_top.sv
module test_tmr_top;
  logic clk = 1'b0;
  logic rst_n;
  logic tick_4k, tick_64, tick_1, tick_min;
  logic run_wr, run_val, src_wr, mode_wr, ie_val, pulse_val, cnt_wr, flag_clr;
  logic [1:0] src_val;
  logic [7:0] cnt_val;
  logic [7:0] count;
  logic flag, irq_n;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tmr_top i_tmr_top (
    .clk(clk), .rst_n(rst_n),
    .tick_4k(tick_4k), .tick_64(tick_64), .tick_1(tick_1), .tick_min(tick_min),
    .run_wr(run_wr), .run_val(run_val), .src_wr(src_wr), .src_val(src_val),
    .mode_wr(mode_wr), .ie_val(ie_val), .pulse_val(pulse_val),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val), .flag_clr(flag_clr),
    .count(count), .flag(flag), .irq_n(irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    {tick_4k, tick_64, tick_1, tick_min} = '0;
    {run_wr, run_val, src_wr, mode_wr, ie_val, pulse_val, cnt_wr, flag_clr} = '0;
    src_val = '0;
    cnt_val = '0;
  endtask

  // idx: 0 = 4 kHz, 1 = 64 Hz, 2 = 1 Hz, 3 = per minute
  task automatic tick(input int idx);
    case (idx)
      0: tick_4k = 1'b1;
      1: tick_64 = 1'b1;
      2: tick_1 = 1'b1;
      default: tick_min = 1'b1;
    endcase
    cyc();
    {tick_4k, tick_64, tick_1, tick_min} = '0;
  endtask

  task automatic load(input int v);
    cnt_wr = 1'b1;
    cnt_val = 8'(v);
    cyc();
    cnt_wr = 1'b0;
  endtask

  task automatic set_run(input bit v);
    run_wr = 1'b1;
    run_val = v;
    cyc();
    run_wr = 1'b0;
  endtask

  task automatic set_src(input int s);
    src_wr = 1'b1;
    src_val = 2'(s);
    cyc();
    src_wr = 1'b0;
  endtask

  task automatic set_mode(input bit ie, input bit pm);
    mode_wr = 1'b1;
    ie_val = ie;
    pulse_val = pm;
    cyc();
    mode_wr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    cyc();
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 flag", flag, 0);
    check("R1 irq_n", irq_n, 1);
  endtask

  task automatic t_default_src();
    load(2);
    set_run(1);
    tick(0);
    tick(1);
    tick(2);
    check("R1 non-default ticks ignored", count, 2);
    tick(3);
    check("R1 default source is per-minute", count, 1);
  endtask

  task automatic t_sources();
    for (int s = 0; s < 3; s++) begin
      set_src(s);
      load(5);
      for (int o = 0; o < 4; o++) begin
        if (o != s) tick(o);
      end
      check("R2 other ticks ignored", count, 5);
      tick(s);
      check("R2 selected tick", count, 4);
    end
  endtask

  task automatic t_hold();
    set_src(0);
    load(7);
    set_run(0);
    tick(0);
    tick(0);
    check("R3 off holds", count, 7);
    set_run(1);
    tick(0);
    tick(0);
    tick(0);
    check("R3 counts down", count, 4);
  endtask

  task automatic t_write_wins();
    tick_4k = 1'b1;
    cnt_wr = 1'b1;
    cnt_val = 8'd9;
    cyc();
    tick_4k = 1'b0;
    cnt_wr = 1'b0;
    check("R4 write over tick", count, 9);
  endtask

  task automatic t_reload();
    load(3);
    tick(0);
    tick(0);
    check("R5 at one", count, 1);
    check("R5 flag before end", flag, 0);
    tick(0);
    check("R5 reload", count, 3);
    check("R5 flag set", flag, 1);
    tick(0);
    check("R7 flag stays", flag, 1);
    clear_flag();
    check("R7 clear", flag, 0);
  endtask

  task automatic t_zero();
    load(0);
    tick(0);
    tick(0);
    check("R6 count parked", count, 0);
    check("R6 no flag", flag, 0);
  endtask

  task automatic t_clear_race();
    load(1);
    tick_4k = 1'b1;
    flag_clr = 1'b1;
    cyc();
    tick_4k = 1'b0;
    flag_clr = 1'b0;
    check("R7 set wins over clear", flag, 1);
    clear_flag();
  endtask

  task automatic t_level();
    set_mode(1, 0);
    check("R8 idle high", irq_n, 1);
    load(1);
    tick(0);
    check("R8 low with flag", irq_n, 0);
    cyc();
    check("R8 stays low", irq_n, 0);
    set_mode(0, 0);
    check("R10 masked", irq_n, 1);
    set_mode(1, 0);
    clear_flag();
    check("R8 high after clear", irq_n, 1);
  endtask

  task automatic t_pulse_fast();
    set_mode(1, 1);
    load(2);
    tick(0);
    check("R9 no pulse yet", irq_n, 1);
    tick(0);
    check("R9 pulse low", irq_n, 0);
    cyc();
    check("R9 pulse held", irq_n, 0);
    tick(0);
    check("R9 pulse ends", irq_n, 1);
    check("R9 flag stays", flag, 1);
    clear_flag();
  endtask

  task automatic t_pulse_slow();
    set_src(3);
    load(1);
    tick(3);
    check("R9 slow pulse low", irq_n, 0);
    tick(2);
    check("R9 1 Hz does not end", irq_n, 0);
    tick(1);
    check("R9 64 Hz ends", irq_n, 1);
    check("R9 slow flag stays", flag, 1);
    set_mode(0, 1);
    check("R10 masked pulse mode", irq_n, 1);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_src();
    t_sources();
    t_hold();
    t_write_wins();
    t_reload();
    t_zero();
    t_clear_race();
    t_level();
    t_pulse_fast();
    t_pulse_slow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule